// File: doc/BRIEF.md
# Ternary Two-Input Logic Gate Unit

This unit evaluates one ternary logic function on two balanced trits and produces one balanced trit. Each trit can hold one of three values, ordered negative < zero < positive. On the wire a trit is a two-bit code: bit 1 marks negative and bit 0 marks positive. Code 2'b10 is negative, 2'b00 is zero and 2'b01 is positive. Code 2'b11 is not a legal trit.

A three-bit select picks the function. The encodings are:
- 0 minimum
- 1 maximum
- 2 inverted minimum
- 3 inverted maximum
- 4 rotating NAND
- 5 inversion of operand A
- 6 buffer of operand A
- 7 unused

Inversion leaves zero unchanged and swaps negative with positive. If either operand carries the illegal code, or the select is unused, the error flag rises and the result is forced to zero.

A parameter chooses the output timing. With the default the result and flag sit in a register with a synchronous active-high reset, which adds one clock of latency. With the other setting they follow the inputs directly.

Top module: `tern_gate_unit`

## Requirements
- R1: If a_i or b_i equals 2'b11, then err_o is 1 and y_o is 2'b00 (zero). This holds whatever the select, including the single-operand selects.
- R2: Select 0 gives the smaller of A and B. Equal operands return that value. Any negative operand gives negative.
- R3: Select 1 gives the larger of A and B.
- R4: Select 2 gives the inversion of the select-0 result.
- R5: Select 3 gives the inversion of the select-1 result.
- R6: Select 4 gives positive for every legal pair except two. Both positive gives negative, and both negative gives zero.
- R7: Select 5 gives the inversion of A: zero stays zero, and negative and positive swap. B does not affect y_o.
- R8: Select 6 passes A through unchanged. B does not affect y_o.
- R9: Select 7 sets err_o to 1 and y_o to zero, even with legal operands.
- R10: With REG_OUT=1, y_o and err_o change only at a rising clock edge, and reflect the inputs present just before that edge. A reset at an edge clears y_o to zero and err_o to 0.
- R11: y_o never carries the code 2'b11.
- R12: With both operands limited to negative and positive, selects 0 and 1 act as binary AND and OR, with positive read as true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 2 | Operand A trit code |
| b_i | input | 2 | Operand B trit code |
| op_i | input | 3 | Function select |
| y_o | output | 2 | Result trit code |
| err_o | output | 1 | Illegal operand code or unused select |

## Verification
The bench walks all nine legal operand pairs through every function. It compares each result with values obtained by integer comparison on -1, 0 and +1. This catches a swapped code bit, an inversion applied to the wrong function, or a rotating NAND with its two special cases exchanged.

Several directed cases follow. An illegal code is placed only on B under a single-operand select; a design that checks only the operands the function uses would miss this flag. The unused select is driven with legal operands; a design that let it fall into a real function would return a nonzero trit with no error. Two timing cases close the run. One samples just before an edge, where a design with no output register would already show the new result. The other applies reset while the inputs would give positive, where a design that lets data win over reset would show a nonzero output.

// File: rtl/tern_pkg.sv
package tern_pkg;

  localparam int TRIT_W = 2;
  localparam int OP_W   = 3;

  typedef logic [TRIT_W-1:0] trit_t;

  // bit 1 flags negative, bit 0 flags positive
  localparam trit_t T_NEG  = 2'b10;
  localparam trit_t T_ZERO = 2'b00;
  localparam trit_t T_POS  = 2'b01;
  localparam trit_t T_BAD  = 2'b11;

  typedef enum logic [OP_W-1:0] {
    OP_MIN   = 3'd0,
    OP_MAX   = 3'd1,
    OP_AMIN  = 3'd2,
    OP_AMAX  = 3'd3,
    OP_RNAND = 3'd4,
    OP_INVA  = 3'd5,
    OP_BUFA  = 3'd6,
    OP_NONE  = 3'd7
  } tern_op_e;

  typedef struct packed {
    logic neg;
    logic pos;
    logic ok;
  } trit_fields_t;

endpackage

// File: rtl/tern_trit_decode.sv
module tern_trit_decode
  import tern_pkg::*;
(
  input  logic [TRIT_W-1:0] code_i,
  output trit_fields_t      f_o
);

  always_comb begin
    f_o.neg = code_i[1] & ~code_i[0];
    f_o.pos = code_i[0] & ~code_i[1];
    f_o.ok  = ~(code_i[1] & code_i[0]);
  end

endmodule

// File: rtl/tern_gate_core.sv
module tern_gate_core
  import tern_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  trit_fields_t      a_i,
  input  trit_fields_t      b_i,
  output logic [TRIT_W-1:0] y_o,
  output logic              err_o
);

  logic lo_neg, lo_pos, hi_neg, hi_pos;
  logic rn_neg, rn_pos;
  logic res_neg, res_pos;
  logic sel_bad;

  // smaller value: negative wins, positive needs both
  assign lo_neg = a_i.neg | b_i.neg;
  assign lo_pos = a_i.pos & b_i.pos;
  // larger value: positive wins, negative needs both
  assign hi_pos = a_i.pos | b_i.pos;
  assign hi_neg = a_i.neg & b_i.neg;
  // rotating NAND: ++ -> -, -- -> 0, otherwise +
  assign rn_neg = a_i.pos & b_i.pos;
  assign rn_pos = ~(a_i.pos & b_i.pos) & ~(a_i.neg & b_i.neg);

  always_comb begin
    res_neg = 1'b0;
    res_pos = 1'b0;
    sel_bad = 1'b0;
    unique case (tern_op_e'(op_i))
      OP_MIN:   begin res_neg = lo_neg; res_pos = lo_pos; end
      OP_MAX:   begin res_neg = hi_neg; res_pos = hi_pos; end
      OP_AMIN:  begin res_neg = lo_pos; res_pos = lo_neg; end
      OP_AMAX:  begin res_neg = hi_pos; res_pos = hi_neg; end
      OP_RNAND: begin res_neg = rn_neg; res_pos = rn_pos; end
      OP_INVA:  begin res_neg = a_i.pos; res_pos = a_i.neg; end
      OP_BUFA:  begin res_neg = a_i.neg; res_pos = a_i.pos; end
      default:  sel_bad = 1'b1;
    endcase
  end

  always_comb begin
    err_o = sel_bad | ~a_i.ok | ~b_i.ok;
    y_o   = err_o ? T_ZERO : {res_neg, res_pos};
  end

endmodule

// File: rtl/tern_out_stage.sv
module tern_out_stage
  import tern_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [TRIT_W-1:0] y_d,
  input  logic              err_d,
  output logic [TRIT_W-1:0] y_q,
  output logic              err_q
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          y_q   <= T_ZERO;
          err_q <= 1'b0;
        end else begin
          y_q   <= y_d;
          err_q <= err_d;
        end
      end
    end else begin : g_comb
      wire unused_clk_rst = clk ^ rst;
      assign y_q   = y_d;
      assign err_q = err_d;
    end
  endgenerate

endmodule

// File: rtl/tern_gate_unit.sv
module tern_gate_unit
  import tern_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  input  logic [2:0] op_i,
  output logic [1:0] y_o,
  output logic       err_o
);

  trit_fields_t        fa, fb;
  logic [TRIT_W-1:0]   y_c;
  logic                err_c;

  tern_trit_decode u_dec_a (.code_i(a_i), .f_o(fa));
  tern_trit_decode u_dec_b (.code_i(b_i), .f_o(fb));

  tern_gate_core u_core (
    .op_i  (op_i),
    .a_i   (fa),
    .b_i   (fb),
    .y_o   (y_c),
    .err_o (err_c)
  );

  tern_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst   (rst),
    .y_d   (y_c),
    .err_d (err_c),
    .y_q   (y_o),
    .err_q (err_o)
  );

endmodule

// File: rtl/tern_gate_unit_chk.sv
module tern_gate_unit_chk #(
  parameter bit REG_OUT = 1'b1
)(
  input logic       clk,
  input logic       rst,
  input logic [1:0] a_i,
  input logic [1:0] b_i,
  input logic [2:0] op_i,
  input logic [1:0] y_o,
  input logic       err_o
);

  assert_legal_out_R11: assert property (@(posedge clk) disable iff (rst)
    y_o != 2'b11);

  assert_err_zero_R1: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (y_o == 2'b00));

  generate
    if (REG_OUT) begin : g_seq
      assert_bad_code_R1: assert property (@(posedge clk) disable iff (rst)
        (a_i == 2'b11 || b_i == 2'b11) |=> err_o);

      assert_bad_op_R9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd7) |=> (err_o && y_o == 2'b00));

      assert_buf_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd6 && a_i != 2'b11 && b_i != 2'b11) |=> (y_o == $past(a_i)));

      assert_min_equal_R2: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0 && a_i == b_i && a_i != 2'b11) |=> (y_o == $past(a_i)));

      assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (y_o == 2'b00 && !err_o));
    end else begin : g_comb
      assert_bad_code_R1: assert property (@(posedge clk) disable iff (rst)
        (a_i == 2'b11 || b_i == 2'b11) |-> err_o);

      assert_bad_op_R9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd7) |-> (err_o && y_o == 2'b00));

      assert_buf_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd6 && a_i != 2'b11 && b_i != 2'b11) |-> (y_o == a_i));

      assert_min_equal_R2: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0 && a_i == b_i && a_i != 2'b11) |-> (y_o == a_i));
    end
  endgenerate

endmodule

bind tern_gate_unit tern_gate_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .a_i   (a_i),
  .b_i   (b_i),
  .op_i  (op_i),
  .y_o   (y_o),
  .err_o (err_o)
);

// File: tb/tern_gate_unit_test.sv
`timescale 1ns/1ps
module tern_gate_unit_test;

  localparam real HALF = 4.0;          // 125 MHz
  localparam int  WATCHDOG = 200000;

  // legal operand pairs, {a, b}
  localparam logic [3:0] PAIRS [9] = '{
    4'b10_10, 4'b10_00, 4'b10_01,
    4'b00_10, 4'b00_00, 4'b00_01,
    4'b01_10, 4'b01_00, 4'b01_01
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] a = 2'b00, b = 2'b00;
  logic [2:0] op = 3'd0;
  logic [1:0] y;
  logic       err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  tern_gate_unit #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .op_i(op), .y_o(y), .err_o(err)
  );

  function automatic int to_int(input logic [1:0] c);
    return (c == 2'b10) ? -1 : (c == 2'b01) ? 1 : 0;
  endfunction

  function automatic logic [1:0] to_code(input int v);
    return (v < 0) ? 2'b10 : (v > 0) ? 2'b01 : 2'b00;
  endfunction

  function automatic int ref_val(input int o, input int x, input int z);
    int lo = (x < z) ? x : z;
    int hi = (x > z) ? x : z;
    case (o)
      0: return lo;
      1: return hi;
      2: return -lo;
      3: return -hi;
      4: return (x == 1 && z == 1) ? -1 : (x == -1 && z == -1) ? 0 : 1;
      5: return -x;
      6: return x;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int o);
    case (o)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] exp_y, input logic exp_e);
    n_chk++;
    if (y !== exp_y || err !== exp_e) begin
      n_fail++;
      $display("FAIL %s: y=%b err=%b expected y=%b err=%b (op=%0d a=%b b=%b)",
               req, y, err, exp_y, exp_e, op, a, b);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [1:0] x, input logic [1:0] z);
    @(negedge clk);
    op = o; a = x; b = z;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset state", 2'b00, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // full table: every function against every legal pair
    for (int o = 0; o < 7; o++) begin
      for (int p = 0; p < 9; p++) begin
        apply(3'(o), PAIRS[p][3:2], PAIRS[p][1:0]);
        check(req_of(o),
              to_code(ref_val(o, to_int(PAIRS[p][3:2]), to_int(PAIRS[p][1:0]))),
              1'b0);
        if (y === 2'b11) begin
          n_fail++;
          $display("FAIL R11: y=%b expected legal code", y);
        end
        n_chk++;
      end
    end

    // R12: binary subset, + is true
    apply(3'd0, 2'b01, 2'b10); check("R12 and 1,0", 2'b10, 1'b0);
    apply(3'd0, 2'b01, 2'b01); check("R12 and 1,1", 2'b01, 1'b0);
    apply(3'd1, 2'b10, 2'b01); check("R12 or 0,1",  2'b01, 1'b0);
    apply(3'd1, 2'b10, 2'b10); check("R12 or 0,0",  2'b10, 1'b0);

    // R1: illegal code on either side
    apply(3'd0, 2'b11, 2'b01); check("R1 bad a min",   2'b00, 1'b1);
    apply(3'd1, 2'b01, 2'b11); check("R1 bad b max",   2'b00, 1'b1);
    apply(3'd6, 2'b01, 2'b11); check("R1 bad b buf",   2'b00, 1'b1);
    apply(3'd5, 2'b10, 2'b11); check("R1 bad b inv",   2'b00, 1'b1);
    apply(3'd4, 2'b11, 2'b11); check("R1 both bad",    2'b00, 1'b1);

    // R7, R8: B has no effect on single-operand selects
    apply(3'd5, 2'b01, 2'b10); check("R7 b ignored",   2'b10, 1'b0);
    apply(3'd5, 2'b01, 2'b01); check("R7 b ignored",   2'b10, 1'b0);
    apply(3'd6, 2'b10, 2'b01); check("R8 b ignored",   2'b10, 1'b0);

    // R9: unused select
    apply(3'd7, 2'b01, 2'b01); check("R9 unused op",   2'b00, 1'b1);
    apply(3'd7, 2'b00, 2'b10); check("R9 unused op",   2'b00, 1'b1);

    // R10: latency, output holds until the edge
    apply(3'd1, 2'b01, 2'b00);
    check("R10 settle", 2'b01, 1'b0);
    @(negedge clk);
    op = 3'd0; a = 2'b10; b = 2'b10;
    #1;
    check("R10 before edge", 2'b01, 1'b0);
    @(posedge clk); #1;
    check("R10 after edge", 2'b10, 1'b0);

    // R10: reset wins over data
    @(negedge clk);
    op = 3'd1; a = 2'b01; b = 2'b01; rst = 1'b1;
    @(posedge clk); #1;
    check("R10 reset mid-run", 2'b00, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R10 after release", 2'b01, 1'b0);

    done = 1;
    finish_run();
  end

endmodule